// File: doc/BRIEF.md
# I2C Master Write-Then-Read Transaction Sequencer

This block runs a complete I2C master transaction, from START to STOP, on top of a byte-level I2C engine. The engine reports bus events as 8-bit status codes. The sequencer answers each event with one command: start, stop, send a byte, or receive a byte that is followed by ACK or by NACK. Bit timing, clock stretching and slave operation stay inside the engine.

Before a transaction the host fills a byte buffer through a simple write port. Byte 0 is the address with the write bit. The write data follow it. When a read phase is wanted, the address with the read bit sits at index `wr_len`. The host sets `wr_len`, which counts the bytes of the write phase including byte 0, and `rd_len`, the number of bytes to read. It then pulses `go`. A transaction always opens with its write phase. A nonzero `rd_len` turns it around with a repeated START, and each received byte is stored in a receive buffer that the host reads through `rx_addr`/`rx_data`. The transaction ends with a one-cycle `done` and a terminal result code. The host may also poll `result` until bit 8 is set.

States: IDLE (waiting for `go`), ARM (START requested, waiting for the START-sent event with a watchdog running), WRITE (address-write and data phase) and READ (address-read and data-receive phase). Transitions: IDLE→ARM on `go`; ARM→WRITE on status 0x08; WRITE→READ on status 0x10; ARM→IDLE on watchdog expiry; any busy state→IDLE on a terminal event (0x20, 0x30, 0x38, 0x48, 0x58, or 0x28 with the write data used up and `rd_len` zero).

Top module: `i2c_xact_seq`

## Requirements
- R1: In IDLE, a `go` pulse moves the block to ARM. In the next cycle `cmd_op` carries START (1), `result` reads 0x000 and `busy` is high. Command encoding: 0 none, 1 START, 2 STOP, 3 SEND (byte on `cmd_byte`), 4 receive then ACK, 5 receive then NACK.
- R2: Status 0x08 answers with SEND of buffer byte 0, sets the write index to 1 and makes `result` read 0x001 (pending).
- R3: Status 0x18 answers with SEND of the buffer byte at the write index. Status 0x28 does the same as long as the write index is below `wr_len`. Each SEND advances the index.
- R4: On status 0x28 with the write index equal to `wr_len`, the block issues START when `rd_len` is nonzero. Otherwise it issues STOP and ends with 0x100 (success).
- R5: Status 0x10 clears the read index and answers with SEND of the buffer byte at the write index, which is the byte at index `wr_len`.
- R6: Status 0x20 and status 0x48 each issue STOP and end with 0x102 (address not acknowledged).
- R7: Status 0x30 issues STOP and ends with 0x101 (data not acknowledged).
- R8: Status 0x38 ends with 0x103 (arbitration lost) and issues no command.
- R9: Status 0x40 answers with receive-NACK (5) when `rd_len` is 1 and with receive-ACK (4) otherwise. Status 0x50 answers with ACK while the incremented read index is below `rd_len`−1 and with NACK otherwise. Status 0x58 issues STOP and ends with 0x100.
- R10: On status 0x50 and on status 0x58 the byte on `evt_rxbyte` is stored at the current read index, so that after the transaction receive byte k reads back at `rx_addr` = k.
- R11: While busy, every event is acknowledged by a one-cycle `stat_ack`. An unknown code issues no command and changes neither the result nor the state. In IDLE, events get no acknowledge and no response.
- R12: If status 0x08 has not arrived within `START_TIMEOUT` cycles of the cycle in which START is issued, the block issues STOP and ends with 0x104.
- R13: Every terminal code has bit 8 set. `done` is high for exactly the one cycle in which the code first appears. `result` then holds until the next accepted `go`. After reset `result` is 0x000 and `done`, `busy` and `cmd_op` are 0.
- R14: A `go` while busy is ignored and issues no START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_we | input | 1 | Host write strobe for the transmit buffer |
| hb_addr | input | $clog2(WBUF_DEPTH) | Transmit buffer write address |
| hb_data | input | 8 | Transmit buffer write data |
| wr_len | input | $clog2(WBUF_DEPTH+1) | Write-phase byte count, address byte included |
| rd_len | input | $clog2(RBUF_DEPTH+1) | Number of bytes to read |
| go | input | 1 | Start one transaction (ignored while busy) |
| evt_valid | input | 1 | Engine status code valid this cycle |
| evt_code | input | 8 | Engine status code |
| evt_rxbyte | input | 8 | Byte received by the engine |
| cmd_op | output | 3 | Command to the engine, 0 = none |
| cmd_byte | output | 8 | Byte to send with a SEND command |
| stat_ack | output | 1 | Status event acknowledged |
| rx_addr | input | $clog2(RBUF_DEPTH) | Receive buffer read address |
| rx_data | output | 8 | Receive buffer read data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when a terminal code is reached |
| result | output | 9 | Transaction result code |

## Verification
Every engine event gets its command, `stat_ack`, `done` and result update exactly one cycle after it, because all of these outputs are registered from the single edge that samples the event. The bench drives each event on a falling edge and checks the answer on the very next falling edge. A late or early answer therefore counts as a miscompare. The exception is the start watchdog, whose STOP is due exactly `START_TIMEOUT` cycles after START appears. The bench counts falling edges from START and expects the STOP on exactly that one. Receive-buffer contents are combinational from `rx_addr` and are sampled a moment after the address is set.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_START   = 3'd1,
        OP_STOP    = 3'd2,
        OP_SEND    = 3'd3,
        OP_RX_ACK  = 3'd4,
        OP_RX_NACK = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARM  = 2'd1,
        S_WR   = 2'd2,
        S_RD   = 2'd3
    } fsm_e;

    // engine status codes
    localparam logic [7:0] EV_START     = 8'h08;
    localparam logic [7:0] EV_RSTART    = 8'h10;
    localparam logic [7:0] EV_AW_ACK    = 8'h18;
    localparam logic [7:0] EV_AW_NAK    = 8'h20;
    localparam logic [7:0] EV_TXD_ACK   = 8'h28;
    localparam logic [7:0] EV_TXD_NAK   = 8'h30;
    localparam logic [7:0] EV_ARB_LOST  = 8'h38;
    localparam logic [7:0] EV_AR_ACK    = 8'h40;
    localparam logic [7:0] EV_AR_NAK    = 8'h48;
    localparam logic [7:0] EV_RXD_ACK   = 8'h50;
    localparam logic [7:0] EV_RXD_NAK   = 8'h58;

    // result codes; bit 8 marks a terminal code
    localparam logic [8:0] RES_IDLE     = 9'h000;
    localparam logic [8:0] RES_PEND     = 9'h001;
    localparam logic [8:0] RES_OK       = 9'h100;
    localparam logic [8:0] RES_DATA_NAK = 9'h101;
    localparam logic [8:0] RES_ADDR_NAK = 9'h102;
    localparam logic [8:0] RES_ARB      = 9'h103;
    localparam logic [8:0] RES_TIMEOUT  = 9'h104;

endpackage

// File: rtl/i2cx_regfile.sv
module i2cx_regfile #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [WIDTH-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (we && (waddr == AW'(g))) begin
                q <= wdata;
            end
        end
        assign ent[g] = q;
    end

    assign rdata = ent[raddr];

endmodule

// File: rtl/i2cx_start_wdog.sv
module i2cx_start_wdog #(
    parameter int LIMIT = 64,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    logic [CW-1:0] cnt;

    assign expired = run && (cnt == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/i2cx_ctrl.sv
module i2cx_ctrl
    import i2cx_pkg::*;
#(
    parameter int AW  = 4,
    parameter int LW  = 5,
    parameter int RAW = 4,
    parameter int RLW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [LW-1:0]  wr_len,
    input  logic [RLW-1:0] rd_len,
    input  logic           evt_valid,
    input  logic [7:0]     evt_code,
    input  logic [7:0]     evt_rxbyte,
    // transmit buffer read
    output logic [AW-1:0]  tx_idx,
    input  logic [7:0]     tx_byte,
    // start watchdog
    output logic           tmo_run,
    input  logic           tmo_expired,
    // receive buffer write
    output logic           rx_we,
    output logic [RAW-1:0] rx_waddr,
    output logic [7:0]     rx_wdata,
    // engine and host side
    output op_e            cmd_op,
    output logic [7:0]     cmd_byte,
    output logic           stat_ack,
    output logic           done,
    output logic [8:0]     result,
    output logic           busy
);

    fsm_e           state, state_n;
    logic [LW-1:0]  wr_idx, wr_idx_n;
    logic [RLW-1:0] rd_idx, rd_idx_n;
    op_e            op_n;
    logic [7:0]     byte_n;
    logic           ack_n;
    logic           done_n;
    logic [8:0]     res_n;

    logic           is_start_evt;
    logic           wr_left;
    logic           rd_more;

    assign busy     = (state != S_IDLE);
    assign tmo_run  = (state == S_ARM);

    assign is_start_evt = evt_valid && (evt_code == EV_START);
    assign tx_idx       = is_start_evt ? '0 : wr_idx[AW-1:0];
    assign wr_left      = (wr_idx < wr_len);
    assign rd_more      = (({1'b0, rd_idx} + (RLW+1)'(2)) < {1'b0, rd_len});

    assign rx_waddr = rd_idx[RAW-1:0];
    assign rx_wdata = evt_rxbyte;

    // next-state and next-output decision
    always_comb begin
        state_n  = state;
        wr_idx_n = wr_idx;
        rd_idx_n = rd_idx;
        op_n     = OP_NONE;
        byte_n   = 8'h00;
        ack_n    = 1'b0;
        done_n   = 1'b0;
        res_n    = result;
        rx_we    = 1'b0;

        unique case (state)
            S_IDLE: begin
                if (go) begin
                    state_n  = S_ARM;
                    op_n     = OP_START;
                    res_n    = RES_IDLE;
                    wr_idx_n = '0;
                    rd_idx_n = '0;
                end
            end
            S_ARM, S_WR, S_RD: begin
                if (evt_valid) begin
                    ack_n = 1'b1;
                    case (evt_code)
                        EV_START: begin
                            op_n     = OP_SEND;
                            byte_n   = tx_byte;
                            wr_idx_n = LW'(1);
                            res_n    = RES_PEND;
                            state_n  = S_WR;
                        end
                        EV_RSTART: begin
                            rd_idx_n = '0;
                            op_n     = OP_SEND;
                            byte_n   = tx_byte;
                            wr_idx_n = wr_idx + 1'b1;
                            state_n  = S_RD;
                        end
                        EV_AW_ACK: begin
                            op_n     = OP_SEND;
                            byte_n   = tx_byte;
                            wr_idx_n = wr_idx + 1'b1;
                        end
                        EV_TXD_ACK: begin
                            if (wr_left) begin
                                op_n     = OP_SEND;
                                byte_n   = tx_byte;
                                wr_idx_n = wr_idx + 1'b1;
                            end else if (rd_len != '0) begin
                                op_n = OP_START;
                            end else begin
                                op_n    = OP_STOP;
                                res_n   = RES_OK;
                                done_n  = 1'b1;
                                state_n = S_IDLE;
                            end
                        end
                        EV_AW_NAK, EV_AR_NAK: begin
                            op_n    = OP_STOP;
                            res_n   = RES_ADDR_NAK;
                            done_n  = 1'b1;
                            state_n = S_IDLE;
                        end
                        EV_TXD_NAK: begin
                            op_n    = OP_STOP;
                            res_n   = RES_DATA_NAK;
                            done_n  = 1'b1;
                            state_n = S_IDLE;
                        end
                        EV_ARB_LOST: begin
                            res_n   = RES_ARB;
                            done_n  = 1'b1;
                            state_n = S_IDLE;
                        end
                        EV_AR_ACK: begin
                            op_n = (rd_len == RLW'(1)) ? OP_RX_NACK : OP_RX_ACK;
                        end
                        EV_RXD_ACK: begin
                            rx_we    = 1'b1;
                            rd_idx_n = rd_idx + 1'b1;
                            op_n     = rd_more ? OP_RX_ACK : OP_RX_NACK;
                        end
                        EV_RXD_NAK: begin
                            rx_we    = 1'b1;
                            rd_idx_n = rd_idx + 1'b1;
                            op_n     = OP_STOP;
                            res_n    = RES_OK;
                            done_n   = 1'b1;
                            state_n  = S_IDLE;
                        end
                        default: begin
                            // unknown code: acknowledged only
                        end
                    endcase
                end else if ((state == S_ARM) && tmo_expired) begin
                    op_n    = OP_STOP;
                    res_n   = RES_TIMEOUT;
                    done_n  = 1'b1;
                    state_n = S_IDLE;
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            wr_idx <= '0;
            rd_idx <= '0;
        end else begin
            state  <= state_n;
            wr_idx <= wr_idx_n;
            rd_idx <= rd_idx_n;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_op   <= OP_NONE;
            cmd_byte <= 8'h00;
            stat_ack <= 1'b0;
            done     <= 1'b0;
            result   <= RES_IDLE;
        end else begin
            cmd_op   <= op_n;
            cmd_byte <= byte_n;
            stat_ack <= ack_n;
            done     <= done_n;
            result   <= res_n;
        end
    end

endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
    import i2cx_pkg::*;
#(
    parameter int WBUF_DEPTH    = 16,
    parameter int RBUF_DEPTH    = 16,
    parameter int START_TIMEOUT = 64,
    localparam int AW  = $clog2(WBUF_DEPTH),
    localparam int LW  = $clog2(WBUF_DEPTH + 1),
    localparam int RAW = $clog2(RBUF_DEPTH),
    localparam int RLW = $clog2(RBUF_DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hb_we,
    input  logic [AW-1:0]  hb_addr,
    input  logic [7:0]     hb_data,
    input  logic [LW-1:0]  wr_len,
    input  logic [RLW-1:0] rd_len,
    input  logic           go,
    input  logic           evt_valid,
    input  logic [7:0]     evt_code,
    input  logic [7:0]     evt_rxbyte,
    output logic [2:0]     cmd_op,
    output logic [7:0]     cmd_byte,
    output logic           stat_ack,
    input  logic [RAW-1:0] rx_addr,
    output logic [7:0]     rx_data,
    output logic           busy,
    output logic           done,
    output logic [8:0]     result
);

    logic [AW-1:0]  tx_idx;
    logic [7:0]     tx_byte;
    logic           tmo_run;
    logic           tmo_expired;
    logic           rx_we;
    logic [RAW-1:0] rx_waddr;
    logic [7:0]     rx_wdata;
    op_e            op_q;

    assign cmd_op = op_q;

    i2cx_regfile #(.DEPTH(WBUF_DEPTH), .WIDTH(8)) u_txbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (hb_we),
        .waddr (hb_addr),
        .wdata (hb_data),
        .raddr (tx_idx),
        .rdata (tx_byte)
    );

    i2cx_regfile #(.DEPTH(RBUF_DEPTH), .WIDTH(8)) u_rxbuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rx_we),
        .waddr (rx_waddr),
        .wdata (rx_wdata),
        .raddr (rx_addr),
        .rdata (rx_data)
    );

    i2cx_start_wdog #(.LIMIT(START_TIMEOUT)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmo_run),
        .expired (tmo_expired)
    );

    i2cx_ctrl #(.AW(AW), .LW(LW), .RAW(RAW), .RLW(RLW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .wr_len      (wr_len),
        .rd_len      (rd_len),
        .evt_valid   (evt_valid),
        .evt_code    (evt_code),
        .evt_rxbyte  (evt_rxbyte),
        .tx_idx      (tx_idx),
        .tx_byte     (tx_byte),
        .tmo_run     (tmo_run),
        .tmo_expired (tmo_expired),
        .rx_we       (rx_we),
        .rx_waddr    (rx_waddr),
        .rx_wdata    (rx_wdata),
        .cmd_op      (op_q),
        .cmd_byte    (cmd_byte),
        .stat_ack    (stat_ack),
        .done        (done),
        .result      (result),
        .busy        (busy)
    );

endmodule

// File: rtl/i2cx_seq_chk.sv
module i2cx_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       evt_valid,
    input logic [7:0] evt_code,
    input logic [2:0] cmd_op,
    input logic       stat_ack,
    input logic       busy,
    input logic       done,
    input logic [8:0] result
);

    assert_cmd_in_xact_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_op != 3'd0) |-> (busy || done));

    assert_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && evt_valid && evt_code == 8'h08) |=> (cmd_op == 3'd3 && result == 9'h001));

    // STOP accompanies every terminal code except arbitration loss (R4, R6, R7, R12)
    assert_stop_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != 9'h103) |-> (cmd_op == 3'd2));

    assert_arb_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 9'h103) |-> (cmd_op == 3'd0));

    assert_idle_evt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && evt_valid) |=> !stat_ack);

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_terminal_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result[8]);

    assert_hold_result_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> $stable(result));

    assert_go_ignored_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go && !evt_valid) |=> (cmd_op != 3'd1));

endmodule

bind i2c_xact_seq i2cx_seq_chk u_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .cmd_op    (cmd_op),
    .stat_ack  (stat_ack),
    .busy      (busy),
    .done      (done),
    .result    (result)
);

// File: tb/i2c_xact_seq_bench.sv
module i2c_xact_seq_bench;

    localparam int TMO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hb_we = 1'b0;
    logic [3:0] hb_addr = '0;
    logic [7:0] hb_data = '0;
    logic [4:0] wr_len = '0;
    logic [4:0] rd_len = '0;
    logic       go = 1'b0;
    logic       evt_valid = 1'b0;
    logic [7:0] evt_code = '0;
    logic [7:0] evt_rxbyte = '0;
    logic [2:0] cmd_op;
    logic [7:0] cmd_byte;
    logic       stat_ack;
    logic [3:0] rx_addr = '0;
    logic [7:0] rx_data;
    logic       busy;
    logic       done;
    logic [8:0] result;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] wb [16];
    logic [7:0] rxe [16];

    always #2 clk = ~clk;

    i2c_xact_seq u_i2c_xact_seq (
        .clk(clk), .rst_n(rst_n), .hb_we(hb_we), .hb_addr(hb_addr), .hb_data(hb_data),
        .wr_len(wr_len), .rd_len(rd_len), .go(go), .evt_valid(evt_valid),
        .evt_code(evt_code), .evt_rxbyte(evt_rxbyte), .cmd_op(cmd_op), .cmd_byte(cmd_byte),
        .stat_ack(stat_ack), .rx_addr(rx_addr), .rx_data(rx_data), .busy(busy),
        .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

    task automatic send_evt(input logic [7:0] code, input logic [7:0] rb);
        @(negedge clk);
        evt_valid  = 1'b1;
        evt_code   = code;
        evt_rxbyte = rb;
        @(negedge clk);
        evt_valid  = 1'b0;
    endtask

    task automatic expect_cmd(input logic [2:0] op, input logic [7:0] b, input string tag);
        chk(cmd_op == op, tag, cmd_op, op);
        if (op == 3'd3) chk(cmd_byte == b, tag, cmd_byte, b);
        chk(stat_ack == 1'b1, tag, stat_ack, 1);
    endtask

    // terminal answer visible now; done must drop next cycle, result holds
    task automatic expect_end(input logic [2:0] op, input logic [8:0] res, input string tag);
        chk(cmd_op == op, tag, cmd_op, op);
        chk(done == 1'b1, tag, done, 1);
        chk(result == res, tag, result, res);
        @(negedge clk);
        chk(done == 1'b0, "R13", done, 0);
        chk(busy == 1'b0, "R13", busy, 0);
        // late event in idle: no acknowledge, no response
        send_evt(8'h18, 8'h00);
        chk(stat_ack == 1'b0 && cmd_op == 3'd0, "R11", {stat_ack, cmd_op}, 0);
        chk(result == res, "R13", result, res);
    endtask

    task automatic run_xact(input int wlen, input int rlen, input int fault, input int fpos);
        int idx;
        int n;
        logic [7:0] rb;
        logic [2:0] exp_op;
        for (int i = 0; i < 16; i++) begin
            wb[i] = 8'($urandom);
            @(negedge clk);
            hb_we = 1'b1; hb_addr = 4'(i); hb_data = wb[i];
        end
        @(negedge clk);
        hb_we  = 1'b0;
        wr_len = 5'(wlen);
        rd_len = 5'(rlen);
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(cmd_op == 3'd1, "R1", cmd_op, 1);
        chk(result == 9'h000 && busy, "R1", {busy, result}, 10'h200);
        if (fault == 5) begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
            end while (cmd_op == 3'd0 && n < 1000);
            chk(n == TMO, "R12", n, TMO);
            chk(cmd_op == 3'd2 && done && result == 9'h104, "R12", {done, cmd_op, result}, {1'b1, 3'd2, 9'h104});
            @(negedge clk);
            chk(done == 1'b0, "R13", done, 0);
            return;
        end
        send_evt(8'h08, 8'h00);
        expect_cmd(3'd3, wb[0], "R2");
        chk(result == 9'h001, "R2", result, 9'h001);
        // go while busy
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(cmd_op == 3'd0, "R14", cmd_op, 0);
        // unknown code
        send_evt(8'hF8, 8'h00);
        chk(stat_ack == 1'b1 && cmd_op == 3'd0, "R11", {stat_ack, cmd_op}, 4'h8);
        chk(result == 9'h001, "R11", result, 9'h001);
        if (fault == 1) begin
            send_evt(8'h20, 8'h00);
            expect_end(3'd2, 9'h102, "R6");
            return;
        end
        send_evt(8'h18, 8'h00);
        expect_cmd(3'd3, wb[1], "R3");
        idx = 2;
        forever begin
            if (fault == 2 && idx - 1 == fpos) begin
                send_evt(8'h30, 8'h00);
                expect_end(3'd2, 9'h101, "R7");
                return;
            end
            if (fault == 4 && idx - 1 == fpos) begin
                send_evt(8'h38, 8'h00);
                chk(cmd_op == 3'd0 && done && result == 9'h103, "R8", {done, cmd_op, result}, {1'b1, 3'd0, 9'h103});
                @(negedge clk);
                chk(done == 1'b0 && result == 9'h103, "R13", {done, result}, 9'h103);
                return;
            end
            send_evt(8'h28, 8'h00);
            if (idx < wlen) begin
                expect_cmd(3'd3, wb[idx], "R3");
                idx++;
            end else begin
                break;
            end
        end
        if (rlen == 0) begin
            expect_end(3'd2, 9'h100, "R4");
            return;
        end
        expect_cmd(3'd1, 8'h00, "R4");
        send_evt(8'h10, 8'h00);
        expect_cmd(3'd3, wb[wlen], "R5");
        if (fault == 3) begin
            send_evt(8'h48, 8'h00);
            expect_end(3'd2, 9'h102, "R6");
            return;
        end
        send_evt(8'h40, 8'h00);
        exp_op = (rlen == 1) ? 3'd5 : 3'd4;
        expect_cmd(exp_op, 8'h00, "R9");
        for (int k = 0; k < rlen - 1; k++) begin
            rb = 8'($urandom);
            rxe[k] = rb;
            send_evt(8'h50, rb);
            exp_op = (k + 1 < rlen - 1) ? 3'd4 : 3'd5;
            expect_cmd(exp_op, 8'h00, "R9");
        end
        rb = 8'($urandom);
        rxe[rlen-1] = rb;
        send_evt(8'h58, rb);
        expect_end(3'd2, 9'h100, "R9");
        for (int k = 0; k < rlen; k++) begin
            @(negedge clk);
            rx_addr = 4'(k);
            #1;
            chk(rx_data == rxe[k], "R10", rx_data, rxe[k]);
        end
    endtask

    initial begin
        int wl;
        int rl;
        int f;
        void'($urandom(32'd2013));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(result == 9'h000 && !done && !busy && cmd_op == 3'd0, "R13",
            {done, busy, cmd_op, result}, 0);
        // directed corners
        run_xact(2, 0, 0, 0);
        run_xact(2, 1, 0, 0);
        run_xact(15, 16, 0, 0);
        run_xact(3, 2, 0, 0);
        run_xact(5, 3, 1, 0);
        run_xact(6, 2, 2, 3);
        run_xact(3, 2, 2, 1);
        run_xact(4, 2, 3, 0);
        run_xact(5, 0, 4, 2);
        run_xact(3, 2, 5, 0);
        // constrained random
        for (int t = 0; t < 30; t++) begin
            wl = 2 + int'($urandom % 14);
            rl = int'($urandom % 17);
            f  = int'($urandom % 6);
            if (f == 3 && rl == 0) f = 0;
            run_xact(wl, rl, f, 1 + int'($urandom % (wl - 1)));
        end
        repeat (4) @(negedge clk);
        report();
    end

endmodule